// File: doc/BRIEF.md
# Adaptive Sample Bit-Window Selector

This block narrows a stream of wide signed converter samples to a short signed word. It keeps a window of adjacent bits whose low edge is set by a shift amount. It also saturates the result whenever the bits above the window carry magnitude that the window cannot hold.

The shift is not fixed. The block adds up the squares of the valid input samples over a block of fixed length and latches that sum as its power estimate. It compares the sum against a high and a low threshold on the cycle the block closes, and moves the window by one position toward the target range. Raising the shift keeps more significant bits.

Software sees a small word-addressed register file. Through it, software can read the power estimate, read or force the shift, set both thresholds and the two shift bounds, and stop automatic tracking. When several bands are processed, each band uses its own instance with its own shift state.

Top module: `bitwin_adapt`

## Requirements
- R1: After reset the shift reads IN_W-OUT_W (8 by default), the power estimate reads 0, the lower bound reads 0, the upper bound reads 8, and the tracking enable reads 1.
- R2: For each valid input sample, the output one cycle later is bits [shift+OUT_W-1 : shift] of the sample, taken as signed. If the bits above that window are not all equal to the sign, the output saturates to +7 or -8 instead. out_valid is in_valid delayed by exactly one cycle.
- R3: The power estimate (register word 1) is the sum of the squares of BLOCK_LEN valid samples. Cycles without a valid sample do not count. It is latched on the cycle that takes the last sample of the block.
- R4: On the cycle a block closes, a sum above the high threshold (word 2) raises the shift by exactly one, unless the shift is already at the upper bound (word 5).
- R5: On the cycle a block closes, a sum below the low threshold (word 3) lowers the shift by exactly one, unless the shift is already at the lower bound (word 4).
- R6: A block sum that is neither above the high threshold nor below the low threshold leaves the shift unchanged. No block moves the shift by more than one step.
- R7: While bit 0 of word 6 is 0, block ends do not change the shift. The power estimate is still latched.
- R8: A write to word 0 sets the shift that the next sample uses. Values above 8 are clamped to 8. The write wins over an automatic step in the same cycle.
- R9: Writes to words 4 and 5 are clamped to 8. Writes to word 1 have no effect on its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | OUT_W | Signed reduced sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr (combinational) |

## Verification
The hardest case to reach is a shift write that lands on the exact cycle a block closes. The clamped shift bounds are also hard to reach, because the shift must first be driven against them over many blocks. The stimulus runs long sequences of blocks with random valid gaps and a chosen amplitude: near full scale, mid-scale or tiny. This walks the shift step by step onto each bound and holds it there. One block then places a word-0 write on its final valid sample, so that the forced value and an automatic step collide.

// File: rtl/bitwin_pkg.sv
package bitwin_pkg;
  typedef enum logic [2:0] {
    RA_SHIFT  = 3'd0,
    RA_POWER  = 3'd1,
    RA_THR_HI = 3'd2,
    RA_THR_LO = 3'd3,
    RA_SH_MIN = 3'd4,
    RA_SH_MAX = 3'd5,
    RA_CTRL   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/bitwin_power.sv
module bitwin_power #(
  parameter int IN_W      = 12,
  parameter int BLOCK_LEN = 1024,
  parameter int ACC_W     = 33
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   blk_end,
  output logic [ACC_W-1:0]       blk_sum,
  output logic [ACC_W-1:0]       power_q
);
  localparam int CNT_W = $clog2(BLOCK_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;

  function automatic logic [ACC_W-1:0] square(input logic signed [IN_W-1:0] x);
    logic signed [2*IN_W-1:0] p;
    p = x * x;
    return ACC_W'($unsigned(p));
  endfunction

  assign blk_end = in_valid && (cnt_q == CNT_W'(BLOCK_LEN - 1));
  assign blk_sum = acc_q + square(in_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      power_q <= '0;
    end else if (in_valid) begin
      if (blk_end) begin
        cnt_q   <= '0;
        acc_q   <= '0;
        power_q <= blk_sum;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= blk_sum;
      end
    end
  end
endmodule

// File: rtl/bitwin_shift_ctl.sv
module bitwin_shift_ctl
  import bitwin_pkg::*;
#(
  parameter int              SH_W       = 4,
  parameter int              MAX_SH     = 8,
  parameter int              ACC_W      = 33,
  parameter int              REG_W      = 40,
  parameter longint unsigned THR_HI_RST = 64'd268435456,
  parameter longint unsigned THR_LO_RST = 64'd16777216
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             blk_end,
  input  logic [ACC_W-1:0] blk_sum,
  input  logic [ACC_W-1:0] power_q,
  output logic [SH_W-1:0]  shift_q,
  output logic [SH_W-1:0]  sh_min_q,
  output logic [SH_W-1:0]  sh_max_q,
  output logic             step_up,
  output logic             step_dn,
  output logic             sw_wr_shift
);
  logic [REG_W-1:0] thr_hi_q, thr_lo_q, sum_ext;
  logic             track_en_q, above, below;
  reg_addr_e        addr;

  function automatic logic [SH_W-1:0] clamp_sh(input logic [REG_W-1:0] v);
    return (v > REG_W'(MAX_SH)) ? SH_W'(MAX_SH) : v[SH_W-1:0];
  endfunction

  assign addr        = reg_addr_e'(reg_addr);
  assign sum_ext     = REG_W'(blk_sum);
  assign above       = sum_ext > thr_hi_q;
  assign below       = sum_ext < thr_lo_q;
  assign step_up     = blk_end && track_en_q && above && (shift_q < sh_max_q);
  assign step_dn     = blk_end && track_en_q && !above && below && (shift_q > sh_min_q);
  assign sw_wr_shift = reg_wr && (addr == RA_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q    <= SH_W'(MAX_SH);
      thr_hi_q   <= REG_W'(THR_HI_RST);
      thr_lo_q   <= REG_W'(THR_LO_RST);
      sh_min_q   <= '0;
      sh_max_q   <= SH_W'(MAX_SH);
      track_en_q <= 1'b1;
    end else begin
      if (sw_wr_shift)  shift_q <= clamp_sh(reg_wdata);
      else if (step_up) shift_q <= shift_q + 1'b1;
      else if (step_dn) shift_q <= shift_q - 1'b1;
      if (reg_wr) begin
        case (addr)
          RA_THR_HI: thr_hi_q   <= reg_wdata;
          RA_THR_LO: thr_lo_q   <= reg_wdata;
          RA_SH_MIN: sh_min_q   <= clamp_sh(reg_wdata);
          RA_SH_MAX: sh_max_q   <= clamp_sh(reg_wdata);
          RA_CTRL:   track_en_q <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      RA_SHIFT:  reg_rdata = REG_W'(shift_q);
      RA_POWER:  reg_rdata = REG_W'(power_q);
      RA_THR_HI: reg_rdata = thr_hi_q;
      RA_THR_LO: reg_rdata = thr_lo_q;
      RA_SH_MIN: reg_rdata = REG_W'(sh_min_q);
      RA_SH_MAX: reg_rdata = REG_W'(sh_max_q);
      RA_CTRL:   reg_rdata = REG_W'(track_en_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bitwin_slicer.sv
module bitwin_slicer #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 4,
  parameter int SH_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic [SH_W-1:0]         shift,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  function automatic logic signed [OUT_W-1:0] window_sat(
      input logic signed [IN_W-1:0] x, input logic [SH_W-1:0] sh);
    logic signed [IN_W-1:0] t;
    logic [IN_W-OUT_W:0]    upper;
    t     = x >>> sh;
    upper = t[IN_W-1:OUT_W-1];
    if ((&upper) || !(|upper)) return t[OUT_W-1:0];
    return t[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= window_sat(in_data, shift);
    end
  end
endmodule

// File: rtl/bitwin_adapt.sv
module bitwin_adapt #(
  parameter int              IN_W       = 12,
  parameter int              OUT_W      = 4,
  parameter int              BLOCK_LEN  = 1024,
  parameter int              REG_W      = 40,
  parameter longint unsigned THR_HI_RST = 64'd268435456,
  parameter longint unsigned THR_LO_RST = 64'd16777216
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  localparam int MAX_SH = IN_W - OUT_W;
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int ACC_W  = 2 * IN_W + $clog2(BLOCK_LEN) - 1;

  logic             blk_end, step_up, step_dn, sw_wr_shift;
  logic [ACC_W-1:0] blk_sum, power_q;
  logic [SH_W-1:0]  shift_q, sh_min_q, sh_max_q;
  logic signed [OUT_W-1:0] slice_out;

  bitwin_power #(.IN_W(IN_W), .BLOCK_LEN(BLOCK_LEN), .ACC_W(ACC_W)) u_pow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .blk_end(blk_end), .blk_sum(blk_sum), .power_q(power_q)
  );

  bitwin_shift_ctl #(
    .SH_W(SH_W), .MAX_SH(MAX_SH), .ACC_W(ACC_W), .REG_W(REG_W),
    .THR_HI_RST(THR_HI_RST), .THR_LO_RST(THR_LO_RST)
  ) u_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_end(blk_end),
    .blk_sum(blk_sum), .power_q(power_q), .shift_q(shift_q),
    .sh_min_q(sh_min_q), .sh_max_q(sh_max_q), .step_up(step_up),
    .step_dn(step_dn), .sw_wr_shift(sw_wr_shift)
  );

  bitwin_slicer #(.IN_W(IN_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_slc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .shift(shift_q), .out_valid(out_valid), .out_data(slice_out)
  );

  assign out_data = slice_out;
endmodule

// File: rtl/bitwin_adapt_chk.sv
module bitwin_adapt_chk #(
  parameter int SH_W   = 4,
  parameter int MAX_SH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            out_valid,
  input logic [SH_W-1:0] shift_q,
  input logic            step_up,
  input logic            step_dn,
  input logic            sw_wr_shift
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  shift_range_chk: assert property (@(posedge clk) disable iff (rst)
    shift_q <= SH_W'(MAX_SH));
  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (step_up && !sw_wr_shift) |=> shift_q == SH_W'($past(shift_q) + 1'b1));
  // R5
  step_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (step_dn && !sw_wr_shift) |=> shift_q == SH_W'($past(shift_q) - 1'b1));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_up && !step_dn && !sw_wr_shift) |=> $stable(shift_q));
  // R6
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step_up, step_dn}));
endmodule

bind bitwin_adapt bitwin_adapt_chk #(.SH_W(SH_W), .MAX_SH(MAX_SH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .shift_q(shift_q), .step_up(step_up), .step_dn(step_dn),
  .sw_wr_shift(sw_wr_shift)
);

// File: tb/sim_bitwin_adapt.sv
`timescale 1ns/1ps
module sim_bitwin_adapt;
  localparam int BLK = 64;
  localparam int RW  = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [11:0]   in_data = '0;
  logic          out_valid;
  logic [3:0]    out_data;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  int shm = 8, mn = 0, mx = 8, cnt = 0;
  bit en = 1;
  longint hi = 268435456, lo = 16777216, acc = 0, pwr = 0;

  bitwin_adapt #(.BLOCK_LEN(BLK), .REG_W(RW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  function automatic int ref_out(int s, int sh);
    int t = s >>> sh;
    if (t > 7) return 7;
    if (t < -8) return -8;
    return t;
  endfunction

  function automatic int clamp8(longint v);
    return (v > 8) ? 8 : int'(v);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, int s, bit w, int a, longint wd);
    int e = 0;
    in_valid = v; in_data = 12'(s);
    reg_wr = w; reg_addr = 3'(a); reg_wdata = RW'(wd);
    if (v) begin
      e = ref_out(s, shm);
      acc += longint'(s) * s;
      cnt++;
      if (cnt == BLK) begin
        pwr = acc; acc = 0; cnt = 0;
        if (en) begin
          if (pwr > hi) begin if (shm < mx) shm++; end
          else if (pwr < lo && shm > mn) shm--;
        end
      end
    end
    if (w) begin
      case (a)
        0: shm = clamp8(wd);
        2: hi = wd;
        3: lo = wd;
        4: mn = clamp8(wd);
        5: mx = clamp8(wd);
        6: en = wd[0];
        default: ;
      endcase
    end
    @(negedge clk);
    reg_wr = 1'b0;
    chk(out_valid == v, "R2 valid", out_valid, v);
    if (v) chk($signed(out_data) == e, "R2 data", $signed(out_data), e);
  endtask

  task automatic rd(int a, longint exp, string req);
    reg_addr = 3'(a);
    #1;
    chk(reg_rdata == RW'(exp), req, reg_rdata, exp);
  endtask

  task automatic wr(int a, longint v);
    step(0, 0, 1, a, v);
  endtask

  // amp: half range of random samples; wlast: write word 0 on last sample
  task automatic run_block(int amp, bit wlast, longint wv, string req);
    int got = 0;
    while (got < BLK) begin
      bit v = ($urandom_range(99, 0) < 80);
      int s = int'($urandom_range(2 * amp, 0)) - amp;
      if (amp == 2047 && $urandom_range(15, 0) == 0) s = -2048;
      if (v) got++;
      step(v, s, (v && got == BLK && wlast), 0, wv);
    end
    rd(0, shm, req);
    rd(1, pwr, "R3 power");
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(0, 8, "R1 shift"); rd(1, 0, "R1 power"); rd(4, 0, "R1 min");
    rd(5, 8, "R1 max"); rd(6, 1, "R1 enable");
    wr(2, BLK * 400 * 400);
    wr(3, BLK * 60 * 60);
    // R4 cap at upper bound
    run_block(2047, 0, 0, "R4 cap");
    // R5 descend to floor
    for (int i = 0; i < 10; i++) run_block(20, 0, 0, "R5 down");
    // R6 mid power holds
    for (int i = 0; i < 2; i++) run_block(500, 0, 0, "R6 hold");
    // R4 rise
    for (int i = 0; i < 3; i++) run_block(2047, 0, 0, "R4 up");
    // R7 tracking disabled
    wr(6, 0);
    for (int i = 0; i < 2; i++) run_block(2047, 0, 0, "R7 frozen");
    wr(6, 1);
    // R9 bound clamps
    wr(4, 13); rd(4, 8, "R9 min clamp");
    wr(5, 15); rd(5, 8, "R9 max clamp");
    wr(4, 2); wr(5, 5);
    for (int i = 0; i < 4; i++) run_block(2047, 0, 0, "R4 upper bound");
    for (int i = 0; i < 5; i++) run_block(20, 0, 0, "R5 lower bound");
    // R8 clamp and next-sample effect
    wr(0, 13); rd(0, 8, "R8 clamp");
    wr(0, 0); rd(0, 0, "R8 write");
    for (int i = 0; i < 8; i++) step(1, int'($urandom_range(4095, 0)) - 2048, 0, 0, 0);
    // R9 power word is read-only
    wr(1, 123); rd(1, pwr, "R9 power ro");
    // R8 write wins over same-cycle step
    run_block(2047, 1, 4, "R8 priority");
    // R2 idle cycles
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule